// File: doc/BRIEF.md
# Bank-Mapping Address Translator

This block sits between an 8-bit CPU core and the rest of the system. It turns each 16-bit logical address into a 21-bit physical address. The logical space is cut into eight windows of 8 KB each. Logical bits [15:13] pick one of eight 8-bit bank registers. That register's value is placed above logical bits [12:0] to form the physical address. The same physical bank number is also decoded into one of three device selects (I/O page, internal RAM, cartridge ROM) or an unmapped flag.

Software loads the bank registers with a single command. The command carries a data byte and an 8-bit one-hot-per-register mask. Every register whose mask bit is set takes the data byte on the same clock edge, so one command can load several windows at once. The same mask also drives a read-back port. That port shows the lowest-numbered selected register, which lets software recover a window's bank.

Translation and region decode are combinational from the register contents. Only the register load is clocked. The reset input is asserted asynchronously and released through a two-stage synchronizer.

Top module: `bank_mapper`

## Requirements
- R1: While reset is held, and after it is released until the first load, every bank register reads 8'h00. Every window then translates to bank 8'h00 with rom_sel high. The top window (logical bits [15:13] = 7) therefore reaches ROM for the vector fetch.
- R2: phys_addr equals {bank, log_addr[12:0]}, where bank is the register indexed by log_addr[15:13].
- R3: When map_we is high at a clock edge and map_mask bit n is set, register n holds map_wdata from that edge on. For example, mask 8'h02 loads window 1 and mask 8'h80 loads window 7.
- R4: A load with several mask bits set writes the same map_wdata into every selected register on one edge.
- R5: A load with map_mask equal to zero leaves every register unchanged.
- R6: With map_we low, no register changes, whatever map_mask and map_wdata carry.
- R7: rd_data returns the register of the lowest-numbered set bit of map_mask. It returns 8'h00 when map_mask is zero.
- R8: Physical bank 8'hFF raises io_sel alone.
- R9: Physical bank 8'hF8 raises ram_sel alone.
- R10: Physical banks 8'h00 through 8'h7F raise rom_sel alone.
- R11: Any other physical bank raises unmapped alone. Exactly one of io_sel, ram_sel, rom_sel and unmapped is high at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| log_addr | input | 16 | CPU logical address |
| map_we | input | 1 | Bank-register load strobe |
| map_mask | input | 8 | Per-register select for load and read-back |
| map_wdata | input | 8 | Bank value to load |
| rd_data | output | 8 | Lowest-numbered selected register |
| phys_addr | output | 21 | Translated physical address |
| io_sel | output | 1 | I/O page selected |
| ram_sel | output | 1 | Internal RAM selected |
| rom_sel | output | 1 | Cartridge ROM selected |
| unmapped | output | 1 | Bank outside every region |

## Verification
Translation is probed in every window with varied offsets. The first probes run straight after reset. Later probes follow single-bit loads, a multi-bit mask load, a zero-mask load and strobe-low traffic. These show whether the window index, the offset bits and the mask fan-out are each wired correctly. Banks at the edges of each region (8'h7F, 8'h80, 8'hF7, 8'hF8, 8'hF9, 8'hFE, 8'hFF) separate the region compares from one another. Read-back masks with several bits set, including one whose lowest bit is high, show whether the priority runs from the low end.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;

  typedef enum logic [1:0] {
    RGN_ROM  = 2'd0,
    RGN_RAM  = 2'd1,
    RGN_IO   = 2'd2,
    RGN_NONE = 2'd3
  } region_e;

endpackage

// File: rtl/bank_rst_sync.sv
module bank_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile #(
  parameter int NUM_WIN = 8,
  parameter int BANK_W  = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [NUM_WIN-1:0]             mask,
  input  logic [BANK_W-1:0]              wdata,
  output logic [NUM_WIN-1:0][BANK_W-1:0] bank_q,
  output logic [BANK_W-1:0]              rd_data
);
  logic [NUM_WIN-1:0][BANK_W-1:0] bank_d;
  logic                           load_en;

  assign load_en = we && (|mask);

  always_comb begin
    bank_d = bank_q;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (mask[i]) bank_d[i] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank_q <= '0;
    else if (load_en) bank_q <= bank_d;
  end

  // lowest selected index wins: scan from the top down
  always_comb begin
    rd_data = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (mask[i]) rd_data = bank_q[i];
    end
  end
endmodule

// File: rtl/bank_region_dec.sv
module bank_region_dec
  import bank_mapper_pkg::*;
#(
  parameter int              BANK_W   = 8,
  parameter logic [BANK_W-1:0] IO_BANK  = 8'hFF,
  parameter logic [BANK_W-1:0] RAM_BANK = 8'hF8,
  parameter logic [BANK_W-1:0] ROM_LAST = 8'h7F
) (
  input  logic [BANK_W-1:0] bank,
  output logic              io_sel,
  output logic              ram_sel,
  output logic              rom_sel,
  output logic              unmapped
);
  region_e rgn;

  always_comb begin
    if (bank == IO_BANK)       rgn = RGN_IO;
    else if (bank == RAM_BANK) rgn = RGN_RAM;
    else if (bank <= ROM_LAST) rgn = RGN_ROM;
    else                       rgn = RGN_NONE;
  end

  assign io_sel   = (rgn == RGN_IO);
  assign ram_sel  = (rgn == RGN_RAM);
  assign rom_sel  = (rgn == RGN_ROM);
  assign unmapped = (rgn == RGN_NONE);
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper #(
  parameter int ADDR_W   = 16,
  parameter int BANK_W   = 8,
  parameter int WIN_BITS = 3,
  parameter logic [BANK_W-1:0] IO_BANK  = 8'hFF,
  parameter logic [BANK_W-1:0] RAM_BANK = 8'hF8,
  parameter logic [BANK_W-1:0] ROM_LAST = 8'h7F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] log_addr,
  input  logic        map_we,
  input  logic [7:0]  map_mask,
  input  logic [7:0]  map_wdata,
  output logic [7:0]  rd_data,
  output logic [20:0] phys_addr,
  output logic        io_sel,
  output logic        ram_sel,
  output logic        rom_sel,
  output logic        unmapped
);
  localparam int NUM_WIN = 1 << WIN_BITS;
  localparam int OFS_W   = ADDR_W - WIN_BITS;

  logic                           rst_sync_n;
  logic [NUM_WIN-1:0][BANK_W-1:0] bank_q;
  logic [WIN_BITS-1:0]            win_idx;
  logic [BANK_W-1:0]              cur_bank;

  bank_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bank_regfile #(.NUM_WIN(NUM_WIN), .BANK_W(BANK_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we      (map_we),
    .mask    (map_mask),
    .wdata   (map_wdata),
    .bank_q  (bank_q),
    .rd_data (rd_data)
  );

  assign win_idx   = log_addr[ADDR_W-1:OFS_W];
  assign cur_bank  = bank_q[win_idx];
  assign phys_addr = {cur_bank, log_addr[OFS_W-1:0]};

  bank_region_dec #(
    .BANK_W(BANK_W), .IO_BANK(IO_BANK), .RAM_BANK(RAM_BANK), .ROM_LAST(ROM_LAST)
  ) u_dec (
    .bank     (cur_bank),
    .io_sel   (io_sel),
    .ram_sel  (ram_sel),
    .rom_sel  (rom_sel),
    .unmapped (unmapped)
  );
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk #(
  parameter int NUM_WIN = 8,
  parameter int BANK_W  = 8
) (
  input logic                           clk,
  input logic                           rst_sync_n,
  input logic [15:0]                    log_addr,
  input logic                           map_we,
  input logic [7:0]                     map_mask,
  input logic [7:0]                     map_wdata,
  input logic [7:0]                     rd_data,
  input logic [20:0]                    phys_addr,
  input logic                           io_sel,
  input logic                           ram_sel,
  input logic                           rom_sel,
  input logic                           unmapped,
  input logic [NUM_WIN-1:0][BANK_W-1:0] bank_q
);
  assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    phys_addr[12:0] == log_addr[12:0]);

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_load
    assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (map_we && map_mask[k]) |=> bank_q[k] == $past(map_wdata));
  end

  assert_zero_mask_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (map_we && map_mask == 8'h00) |=> $stable(bank_q));

  assert_no_strobe_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !map_we |=> $stable(bank_q));

  assert_rd_low_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    map_mask[0] |-> rd_data == bank_q[0]);

  assert_io_bank_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phys_addr[20:13] == 8'hFF) |-> io_sel);

  assert_ram_bank_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phys_addr[20:13] == 8'hF8) |-> ram_sel);

  assert_rom_bank_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !phys_addr[20] |-> rom_sel);

  assert_one_region_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones({io_sel, ram_sel, rom_sel, unmapped}) == 1);
endmodule

bind bank_mapper bank_mapper_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .log_addr   (log_addr),
  .map_we     (map_we),
  .map_mask   (map_mask),
  .map_wdata  (map_wdata),
  .rd_data    (rd_data),
  .phys_addr  (phys_addr),
  .io_sel     (io_sel),
  .ram_sel    (ram_sel),
  .rom_sel    (rom_sel),
  .unmapped   (unmapped),
  .bank_q     (bank_q)
);

// File: tb/bank_mapper_bench.sv
module bank_mapper_bench;
  typedef struct {
    logic [15:0] addr;
    logic [7:0]  mask;
    logic [20:0] phys;
    logic [3:0]  sel;   // {io, ram, rom, unmapped}
    logic [7:0]  rd;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] log_addr;
  logic        map_we;
  logic [7:0]  map_mask;
  logic [7:0]  map_wdata;
  logic [7:0]  rd_data;
  logic [20:0] phys_addr;
  logic        io_sel, ram_sel, rom_sel, unmapped;

  int   total = 0;
  int   bad   = 0;
  bit   done  = 1'b0;
  logic [7:0] mdl [8];
  exp_t sb_q[$];

  always #2 clk = ~clk;

  bank_mapper u_bank_mapper (
    .clk(clk), .rst_n(rst_n), .log_addr(log_addr), .map_we(map_we),
    .map_mask(map_mask), .map_wdata(map_wdata), .rd_data(rd_data),
    .phys_addr(phys_addr), .io_sel(io_sel), .ram_sel(ram_sel),
    .rom_sel(rom_sel), .unmapped(unmapped)
  );

  function automatic logic [3:0] region_of(input logic [7:0] b);
    if (b == 8'hFF)      return 4'b1000;
    else if (b == 8'hF8) return 4'b0100;
    else if (b < 8'h80)  return 4'b0010;
    else                 return 4'b0001;
  endfunction

  function automatic logic [7:0] rd_of(input logic [7:0] m);
    for (int i = 0; i < 8; i++) if (m[i]) return mdl[i];
    return 8'h00;
  endfunction

  // driver: present a probe, push the expected result
  task automatic probe(input logic [15:0] a, input logic [7:0] m, input string req);
    exp_t e;
    @(negedge clk);
    map_we   = 1'b0;
    log_addr = a;
    map_mask = m;
    e.addr = a;
    e.mask = m;
    e.phys = {mdl[a[15:13]], a[12:0]};
    e.sel  = region_of(mdl[a[15:13]]);
    e.rd   = rd_of(m);
    e.req  = req;
    sb_q.push_back(e);
  endtask

  task automatic load(input logic [7:0] m, input logic [7:0] d);
    @(negedge clk);
    map_we    = 1'b1;
    map_mask  = m;
    map_wdata = d;
    for (int i = 0; i < 8; i++) if (m[i]) mdl[i] = d;
    @(negedge clk);
    map_we = 1'b0;
  endtask

  // monitor: combinational outputs, sampled 1 ns after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        total++;
        if (phys_addr !== e.phys || {io_sel, ram_sel, rom_sel, unmapped} !== e.sel
            || rd_data !== e.rd) begin
          bad++;
          $display("FAIL %s addr=%h mask=%h: phys=%h sel=%b rd=%h expected phys=%h sel=%b rd=%h",
                   e.req, e.addr, e.mask, phys_addr, {io_sel, ram_sel, rom_sel, unmapped},
                   rd_data, e.phys, e.sel, e.rd);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    rst_n = 1'b0; log_addr = '0; map_we = 1'b0; map_mask = '0; map_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: state visible while reset is held
    probe(16'hE123, 8'h80, "R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: all windows read bank 00, ROM after reset
    for (int w = 0; w < 8; w++) probe({w[2:0], 13'h0A5A ^ w[12:0]}, 8'h01 << w, "R1");

    // R3 and R8/R9: single-bit loads for windows 0 and 1, window 7 to ROM page
    load(8'h01, 8'hFF);
    load(8'h02, 8'hF8);
    load(8'h80, 8'h00);
    probe(16'h0402, 8'h01, "R3 R8");
    probe(16'h3FFF, 8'h02, "R3 R9");
    probe(16'hFFFC, 8'h80, "R3 R10");
    probe(16'h2000, 8'h03, "R7");

    // R4: one command fills windows 2..6
    load(8'h7C, 8'h40);
    for (int w = 2; w < 7; w++) probe({w[2:0], 13'h1ABC}, 8'h01 << w, "R4 R2");

    // R5: zero mask with strobe high
    load(8'h00, 8'h99);
    for (int w = 0; w < 8; w++) probe({w[2:0], 13'h0001}, 8'h01 << w, "R5");

    // R6: strobe low with mask and data active for a few cycles
    @(negedge clk);
    map_we = 1'b0; map_mask = 8'hFF; map_wdata = 8'h55;
    repeat (3) @(negedge clk);
    for (int w = 0; w < 8; w++) probe({w[2:0], 13'h1000}, 8'h01 << w, "R6");

    // R10/R11 region boundaries
    load(8'h04, 8'h7F); probe(16'h4000, 8'h04, "R10");
    load(8'h04, 8'h80); probe(16'h5555, 8'h04, "R11");
    load(8'h04, 8'hF7); probe(16'h4ABC, 8'h04, "R11");
    load(8'h04, 8'hF9); probe(16'h5FFF, 8'h04, "R11");
    load(8'h04, 8'hFE); probe(16'h4001, 8'h04, "R11");

    // R7: priority and empty mask
    load(8'h20, 8'h3C);
    probe(16'hA000, 8'hA0, "R7");
    probe(16'hA000, 8'h00, "R7");
    probe(16'h8000, 8'h81, "R7");
    // R2: window index and offset from varied addresses
    probe(16'h1FFF, 8'h08, "R2");
    probe(16'hBEEF, 8'h10, "R2");
    probe(16'hC0DE, 8'h40, "R2");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule